// File: doc/BRIEF.md
# Pipelined Nine-Pixel Median Selector

This block receives one 3x3 neighbourhood of pixels per clock, together with a qualifier bit, and returns the middle value of the nine samples a fixed number of cycles later. The selection is made by a levelled compare-exchange network of 19 cells. Every level is followed by a register bank, so a fresh window can enter on every clock and a result leaves on every clock.

A per-window select bit chooses between two answers. The first is the exact median of all nine samples. The second is a cheaper estimate: the median of each group of three samples, followed by the median of those three partial results. The estimate reuses the first three levels of the exact network and adds only three more cells. Both answers come out after the same number of cycles. The select bit can therefore change on any clock, and windows already in the pipeline are not affected.

The window generator, its line buffers and the treatment of the image borders sit upstream and are not part of this block.

Top module: `median9_pipe`

## Requirements
- R1: With `win_mode` = 0 (exact), `med_px` equals the 5th smallest of the nine samples of the window. Sample Pk (k = 1..9) is carried on `win_px[W*(k-1) +: W]`, which is element k-1 of the packed array.
- R2: With `win_mode` = 1 (estimate), `med_px` equals the median of three values: the medians of the groups {P1,P2,P3}, {P4,P5,P6} and {P7,P8,P9}.
- R3: `med_vld` rises exactly 9 rising clock edges after the edge that sampled `win_vld` high. A window sampled with `win_vld` low never produces `med_vld` high, and its data is ignored.
- R4: Windows presented on consecutive clocks give consecutive results, one per clock, with no stall and no lost window.
- R5: `win_mode` is captured together with its window. Toggling it on every clock changes only the result of the window it accompanies.
- R6: `rst` is synchronous and active high. After any clock edge at which `rst` is high, `med_vld` is low, and windows that were in flight at that edge are discarded.
- R7: Equal samples are handled correctly in both modes: an all-equal window returns that value, and windows made of the values 0 and 2^W-1 return the correct one of those two values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset of the qualifier pipeline |
| win_vld | input | 1 | Window qualifier |
| win_mode | input | 1 | 0 = exact median, 1 = median of group medians |
| win_px | input | 9*W | Nine samples; element k-1 holds Pk |
| med_vld | output | 1 | Result qualifier |
| med_px | output | W | Selected median |

## Verification
The hardest case to reach is a change of mode while the window it applies to sits in the pipeline next to windows of the other mode. A wrong alignment of the mode bit only shows up when the two answers differ for the affected window. The stimulus therefore alternates the mode bit on every clock over random windows, which frequently make the two answers disagree. It also sends a directed window whose exact and estimated medians are known to differ, in both modes. A reset is applied while valid windows are still in flight, and the bench then checks that none of them reappears at the output.

// File: rtl/median9_pkg.sv
package median9_pkg;

   localparam int TAPS          = 9;
   localparam int EXACT_LEVELS  = 9;
   localparam int SEL_LEVELS    = 3;
   localparam int ROW_TAP_LEVEL = 3;
   localparam int OPS_PER_LEVEL = 3;
   localparam logic [7:0] NO_OP = 8'hFF;

   typedef enum logic [1:0] {
      NET_EXACT = 2'd0,
      NET_SEL3  = 2'd1,
      NET_HOLD  = 2'd2
   } net_e;

   // Each byte is {lo_lane, hi_lane}; after the cell lo_lane holds the smaller value.
   function automatic logic [23:0] level_word(net_e net, int lvl);
      logic [23:0] w;
      w = {3{NO_OP}};
      if (net == NET_EXACT) begin
         case (lvl)
            0: w = 24'h12_45_78;
            1: w = 24'h01_34_67;
            2: w = 24'h12_45_78;
            3: w = 24'h03_58_47;
            4: w = 24'h36_14_25;
            5: w = 24'h47_FF_FF;
            6: w = 24'h42_FF_FF;
            7: w = 24'h64_FF_FF;
            8: w = 24'h42_FF_FF;
            default: w = {3{NO_OP}};
         endcase
      end else if (net == NET_SEL3) begin
         case (lvl)
            0: w = 24'h01_FF_FF;
            1: w = 24'h12_FF_FF;
            2: w = 24'h01_FF_FF;
            default: w = {3{NO_OP}};
         endcase
      end
      return w;
   endfunction

   function automatic logic [7:0] cx_op(net_e net, int lvl, int k);
      logic [23:0] w;
      w = level_word(net, lvl);
      return w[8*(OPS_PER_LEVEL-1-k) +: 8];
   endfunction

endpackage

// File: rtl/median_cx.sv
module median_cx #(
   parameter int W = 8
) (
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   output logic [W-1:0] lo,
   output logic [W-1:0] hi
);
   logic swap;

   always_comb begin
      swap = (b < a);
      lo   = swap ? b : a;
      hi   = swap ? a : b;
   end

   always_comb begin
      p_cx_order_r1: assert (lo <= hi)
         else $error("compare-exchange outputs out of order");
   end
endmodule

// File: rtl/median_level.sv
module median_level
   import median9_pkg::*;
#(
   parameter int   W   = 8,
   parameter int   N   = 9,
   parameter net_e NET = NET_EXACT,
   parameter int   LVL = 0
) (
   input  logic                clk,
   input  logic [N-1:0][W-1:0] d,
   output logic [N-1:0][W-1:0] q
);
   localparam logic [23:0] WORD = level_word(NET, LVL);

   logic [N-1:0][W-1:0] nx;
   logic [W-1:0]        mn [OPS_PER_LEVEL];
   logic [W-1:0]        mx [OPS_PER_LEVEL];

   if (N < 1) begin : g_bad_n
      $error("median_level: N must be at least 1");
   end

   for (genvar k = 0; k < OPS_PER_LEVEL; k++) begin : g_op
      localparam logic [7:0] OP = WORD[8*(OPS_PER_LEVEL-1-k) +: 8];
      if (OP != NO_OP) begin : g_cell
         localparam int LO = int'(OP[7:4]);
         localparam int HI = int'(OP[3:0]);
         if (LO >= N || HI >= N || LO == HI) begin : g_bad_op
            $error("median_level: cell lanes out of range");
         end
         median_cx #(.W(W)) u_cx (
            .a (d[LO]),
            .b (d[HI]),
            .lo(mn[k]),
            .hi(mx[k])
         );
      end else begin : g_idle
         assign mn[k] = '0;
         assign mx[k] = '0;
      end
   end

   always_comb begin
      nx = d;
      for (int k = 0; k < OPS_PER_LEVEL; k++) begin
         logic [7:0] op;
         op = WORD[8*(OPS_PER_LEVEL-1-k) +: 8];
         if (op != NO_OP) begin
            nx[int'(op[7:4])] = mn[k];
            nx[int'(op[3:0])] = mx[k];
         end
      end
   end

   always_ff @(posedge clk) begin
      q <= nx;
   end
endmodule

// File: rtl/median9_pipe.sv
module median9_pipe
   import median9_pkg::*;
#(
   parameter int W = 8
) (
   input  logic                   clk,
   input  logic                   rst,
   input  logic                   win_vld,
   input  logic                   win_mode,
   input  logic [TAPS-1:0][W-1:0] win_px,
   output logic                   med_vld,
   output logic [W-1:0]           med_px
);
   localparam int LAT       = EXACT_LEVELS;
   localparam int PS_STAGES = LAT - ROW_TAP_LEVEL;
   localparam int AGE_W     = $clog2(LAT + 1);
   localparam int SUM_W     = W + 4;

   if (W < 1 || W > 16) begin : g_bad_w
      $error("median9_pipe: W must lie in 1..16");
   end
   if (PS_STAGES < SEL_LEVELS) begin : g_bad_lat
      $error("median9_pipe: estimate path cannot match exact latency");
   end

   // exact network: one register bank per level
   logic [TAPS-1:0][W-1:0] lv [0:LAT];
   assign lv[0] = win_px;

   for (genvar l = 0; l < LAT; l++) begin : g_exact
      median_level #(.W(W), .N(TAPS), .NET(NET_EXACT), .LVL(l)) u_lvl (
         .clk(clk),
         .d  (lv[l]),
         .q  (lv[l+1])
      );
   end

   // estimate path: group medians tapped after the three group sorts
   logic [2:0][W-1:0] ps [0:PS_STAGES];
   assign ps[0] = {lv[ROW_TAP_LEVEL][7], lv[ROW_TAP_LEVEL][4], lv[ROW_TAP_LEVEL][1]};

   for (genvar l = 0; l < PS_STAGES; l++) begin : g_est
      if (l < SEL_LEVELS) begin : g_sort
         median_level #(.W(W), .N(3), .NET(NET_SEL3), .LVL(l)) u_lvl (
            .clk(clk),
            .d  (ps[l]),
            .q  (ps[l+1])
         );
      end else begin : g_hold
         median_level #(.W(W), .N(3), .NET(NET_HOLD), .LVL(l)) u_lvl (
            .clk(clk),
            .d  (ps[l]),
            .q  (ps[l+1])
         );
      end
   end

   // qualifier and mode travel with the data
   logic [LAT-1:0] vsr;
   logic [LAT-1:0] msr;

   always_ff @(posedge clk) begin
      if (rst) vsr <= '0;
      else     vsr <= {vsr[LAT-2:0], win_vld};
   end

   always_ff @(posedge clk) begin
      msr <= {msr[LAT-2:0], win_mode};
   end

   assign med_vld = vsr[LAT-1];
   assign med_px  = msr[LAT-1] ? ps[PS_STAGES][1] : lv[LAT][4];

   // ---------------- assertions ----------------
   logic [AGE_W-1:0] age;
   always_ff @(posedge clk) begin
      if (rst)                     age <= '0;
      else if (age != AGE_W'(LAT)) age <= age + 1'b1;
   end

   function automatic logic [SUM_W-1:0] lane_sum(input logic [TAPS-1:0][W-1:0] v);
      logic [SUM_W-1:0] s;
      s = '0;
      for (int i = 0; i < TAPS; i++) s = s + {4'b0, v[i]};
      return s;
   endfunction

   p_conserve_r1: assert property (@(posedge clk) disable iff (rst)
      (age == AGE_W'(LAT) && med_vld) |-> lane_sum(lv[LAT]) == $past(lane_sum(win_px), LAT))
      else $error("network lost or duplicated a sample");

   p_rows_sorted_r2: assert property (@(posedge clk) disable iff (rst)
      vsr[ROW_TAP_LEVEL-1] |->
         (lv[ROW_TAP_LEVEL][0] <= lv[ROW_TAP_LEVEL][1]) && (lv[ROW_TAP_LEVEL][1] <= lv[ROW_TAP_LEVEL][2]) &&
         (lv[ROW_TAP_LEVEL][3] <= lv[ROW_TAP_LEVEL][4]) && (lv[ROW_TAP_LEVEL][4] <= lv[ROW_TAP_LEVEL][5]) &&
         (lv[ROW_TAP_LEVEL][6] <= lv[ROW_TAP_LEVEL][7]) && (lv[ROW_TAP_LEVEL][7] <= lv[ROW_TAP_LEVEL][8]))
      else $error("group triples not sorted at tap level");

   p_pseudo_sorted_r2: assert property (@(posedge clk) disable iff (rst)
      med_vld |-> (ps[PS_STAGES][0] <= ps[PS_STAGES][1]) && (ps[PS_STAGES][1] <= ps[PS_STAGES][2]))
      else $error("estimate triple not ordered");

   p_valid_lat_r3: assert property (@(posedge clk) disable iff (rst)
      (age == AGE_W'(LAT)) |-> med_vld == $past(win_vld, LAT))
      else $error("result qualifier misaligned");

   p_reset_clears_r6: assert property (@(posedge clk)
      rst |=> !med_vld)
      else $error("qualifier survived reset");

endmodule

// File: tb/tb_median9_pipe.sv
module tb_median9_pipe;
   localparam int W    = 8;
   localparam int LAT  = 9;
   localparam int MAXV = (1 << W) - 1;

   logic                clk = 1'b0;
   logic                rst = 1'b1;
   logic                win_vld = 1'b0;
   logic                win_mode = 1'b0;
   logic [8:0][W-1:0]   win_px = '0;
   logic                med_vld;
   logic [W-1:0]        med_px;

   always #2 clk = ~clk;

   median9_pipe #(.W(W)) dut (
      .clk(clk), .rst(rst), .win_vld(win_vld), .win_mode(win_mode),
      .win_px(win_px), .med_vld(med_vld), .med_px(med_px)
   );

   typedef struct {
      bit    vld;
      int    val;
      string tag;
   } exp_t;

   exp_t q[$];
   int   n_cmp = 0;
   int   n_bad = 0;
   bit   done  = 0;

   function automatic int med3(int a, int b, int c);
      int lo, hi;
      lo = (a < b) ? a : b;
      hi = (a < b) ? b : a;
      if (c < lo) return lo;
      if (c > hi) return hi;
      return c;
   endfunction

   function automatic int exact_ref(logic [8:0][W-1:0] px);
      int a[9];
      for (int i = 0; i < 9; i++) a[i] = int'(px[i]);
      for (int i = 1; i < 9; i++) begin
         for (int j = i; j > 0; j--) begin
            if (a[j] < a[j-1]) begin
               int t;
               t = a[j]; a[j] = a[j-1]; a[j-1] = t;
            end
         end
      end
      return a[4];
   endfunction

   function automatic int pseudo_ref(logic [8:0][W-1:0] px);
      return med3(med3(int'(px[0]), int'(px[1]), int'(px[2])),
                  med3(int'(px[3]), int'(px[4]), int'(px[5])),
                  med3(int'(px[6]), int'(px[7]), int'(px[8])));
   endfunction

   function automatic logic [8:0][W-1:0] rnd_px(int top);
      logic [8:0][W-1:0] v;
      for (int i = 0; i < 9; i++) v[i] = W'($urandom_range(top, 0));
      return v;
   endfunction

   function automatic logic [8:0][W-1:0] fill_px(int x);
      logic [8:0][W-1:0] v;
      for (int i = 0; i < 9; i++) v[i] = W'(x);
      return v;
   endfunction

   task automatic chk(bit ok, string tag, string what, int act, int expv);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, expv);
      end
   endtask

   task automatic prefill();
      q.delete();
      for (int i = 0; i < LAT; i++) q.push_back('{vld: 1'b0, val: 0, tag: "R3"});
   endtask

   // called at a falling edge: compare, drive next window, advance one cycle
   task automatic step(bit v, bit m, logic [8:0][W-1:0] px, string tag);
      exp_t e;
      e = q.pop_front();
      chk(med_vld == e.vld, e.tag, "med_vld", int'(med_vld), int'(e.vld));
      if (e.vld) chk(int'(med_px) == e.val, e.tag, "med_px", int'(med_px), e.val);
      win_vld  = v;
      win_mode = m;
      win_px   = px;
      q.push_back('{vld: v, val: (m ? pseudo_ref(px) : exact_ref(px)), tag: tag});
      @(negedge clk);
   endtask

   task automatic flush(string tag);
      for (int i = 0; i < LAT; i++) step(1'b0, 1'b0, rnd_px(MAXV), tag);
   endtask

   task automatic summary();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL R3 watchdog: actual 0 expected 1 (run completion)");
         summary();
         $finish;
      end
   end

   initial begin
      logic [8:0][W-1:0] dp;
      // R6: reset state
      repeat (2) @(negedge clk);
      chk(med_vld == 1'b0, "R6", "med_vld in reset", int'(med_vld), 0);
      rst = 1'b0;
      prefill();

      // R3: idle inputs with noisy data give nothing
      for (int i = 0; i < 12; i++) step(1'b0, i[0], rnd_px(MAXV), "R3");

      // R1: exact mode, random windows with gaps
      for (int i = 0; i < 200; i++)
         step(($urandom_range(9, 0) < 7), 1'b0, rnd_px(MAXV), "R1");

      // R4: back-to-back burst
      for (int i = 0; i < 120; i++) step(1'b1, 1'b0, rnd_px(MAXV), "R4");

      // R2: estimate mode
      for (int i = 0; i < 200; i++)
         step(($urandom_range(9, 0) < 8), 1'b1, rnd_px(MAXV), "R2");

      // R1/R2: directed window where the two answers differ (exact 5, estimate 4)
      dp[0] = 8'd1; dp[1] = 8'd2; dp[2] = 8'd9;
      dp[3] = 8'd3; dp[4] = 8'd4; dp[5] = 8'd9;
      dp[6] = 8'd5; dp[7] = 8'd6; dp[8] = 8'd9;
      step(1'b1, 1'b0, dp, "R1");
      step(1'b1, 1'b1, dp, "R2");
      step(1'b1, 1'b0, dp, "R5");
      step(1'b1, 1'b1, dp, "R5");

      // R5: mode toggles every clock, then random mode and random gaps
      for (int i = 0; i < 150; i++) step(1'b1, i[0], rnd_px(MAXV), "R5");
      for (int i = 0; i < 150; i++)
         step(($urandom_range(3, 0) != 0), $urandom_range(1, 0) == 1, rnd_px(MAXV), "R5");

      // R7: equal and extreme values
      for (int m = 0; m < 2; m++) begin
         step(1'b1, m[0], fill_px(0),    "R7");
         step(1'b1, m[0], fill_px(MAXV), "R7");
         step(1'b1, m[0], fill_px(77),   "R7");
      end
      for (int i = 0; i < 120; i++) begin
         logic [8:0][W-1:0] ex;
         for (int k = 0; k < 9; k++) ex[k] = ($urandom_range(1, 0) == 1) ? W'(MAXV) : '0;
         step(1'b1, i[0], ex, "R7");
      end
      for (int i = 0; i < 120; i++) step(1'b1, $urandom_range(1, 0) == 1, rnd_px(3), "R7");
      flush("R3");

      // R6: reset with windows in flight
      for (int i = 0; i < 6; i++) step(1'b1, i[0], rnd_px(MAXV), "R6");
      rst = 1'b1;
      win_vld = 1'b0;
      @(negedge clk);
      chk(med_vld == 1'b0, "R6", "med_vld after reset edge", int'(med_vld), 0);
      @(negedge clk);
      chk(med_vld == 1'b0, "R6", "med_vld held in reset", int'(med_vld), 0);
      rst = 1'b0;
      q.delete();
      for (int i = 0; i < LAT; i++) q.push_back('{vld: 1'b0, val: 0, tag: "R6"});
      for (int i = 0; i < 40; i++) step(1'b1, i[0], rnd_px(MAXV), "R1");
      flush("R3");

      done = 1'b1;
      summary();
      $finish;
   end
endmodule